// File: doc/BRIEF.md
# Destination-Paced DMA Channel Sequencer with Early Source Cut-Off

This block sequences one DMA channel that carries words from a source peripheral into a channel FIFO and from there to a destination peripheral. The destination decides when the block ends: it marks its final single request as the last one. The source is read ahead of need, in bursts, so the FIFO usually holds more words than the destination will still take.

The block watches both handshakes. On the source side it counts completed read beats against the burst length and acknowledges the request. On the destination side it counts write beats and acknowledges each burst or single. Once the destination's last request is pending and the FIFO already holds the word it needs, the block stops reading from the source, even partway through a burst. It then signals the end of the source block in one of two ways. If a source request is still open, the finish strobe joins the acknowledge and is held until the source drops its request. If no source request is open, the finish strobe is a single-cycle pulse. If the last source read was answered with RETRY, the finish waits until that read is repeated and answered OKAY.

When both sides are finished, the block pulses a done strobe together with a clear for the external FIFO. Any words left over from read-ahead are dropped, so the next block starts with an empty FIFO. The bus is abstracted as one strobe per completed read or write beat, with a RETRY flag on reads. The FIFO occupancy is an input.

Top module: `dma_flow_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, src_ack, src_finish, dst_ack, block_done and fifo_clear are all low.
- R2: Once a source request is being served, the block counts read beats with rd_beat high and rd_resp_retry low. After 8 such beats (1 if src_single is high), src_ack rises in the cycle after the last beat's edge. It stays high while src_req is high and falls in the cycle after src_req drops.
- R3: A destination request with dst_single low is acknowledged after 4 wr_beat pulses; with dst_single high it is acknowledged after 1. dst_ack stays high while dst_req is high and falls in the cycle after dst_req drops.
- R4: A request with dst_req, dst_single and dst_last all high, while fifo_count is non-zero, stops source fetching two cycles later. If a source request is open at that point, src_finish and src_ack rise together and stay high until src_req drops.
- R5: If no source request is open when fetching stops, src_finish is high for exactly one cycle and src_ack stays low.
- R6: If the most recent source read beat carried rd_resp_retry high, src_finish is withheld. It rises in the cycle after the next read beat that completes without retry, and that extra word is counted as fetched.
- R7: While fifo_count is zero, a pending last request does not end the source side. Fetching continues and src_finish rises one cycle after the FIFO count becomes non-zero.
- R8: Once the source side has finished and the destination's last single has been acknowledged, block_done and fifo_clear pulse high together for one cycle. The words still in the FIFO at that moment are dropped, and the next block starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 1 | Source transfer request, held until acknowledged |
| src_single | input | 1 | Source request is a single word rather than a burst |
| src_ack | output | 1 | Source acknowledge, handshaked with src_req |
| src_finish | output | 1 | Source block end: held with src_ack, or a one-cycle pulse |
| dst_req | input | 1 | Destination transfer request |
| dst_single | input | 1 | Destination request is a single word |
| dst_last | input | 1 | Destination request is the final one of the block |
| dst_ack | output | 1 | Destination acknowledge, handshaked with dst_req |
| rd_beat | input | 1 | One source read beat completed on the bus |
| rd_resp_retry | input | 1 | The read beat was answered RETRY and must be repeated |
| wr_beat | input | 1 | One destination write beat completed |
| fifo_count | input | 5 | Current occupancy of the external channel FIFO (0 to 16) |
| fifo_clear | output | 1 | Flushes the external FIFO at the end of the block |
| block_done | output | 1 | One-cycle pulse when both sides are complete |

## Verification
On every cycle, assertions check the following. A one-cycle finish never lasts a second cycle. A handshaked finish and its acknowledge stay up while the source still requests. No finish follows straight after a RETRY beat. Every rising finish was preceded by the stop condition. The destination acknowledge holds while its request stands. The done strobe never lasts two cycles. Only the bench scenarios can show the exact cycle of each strobe and which of the two finish forms appears for a given history. They also show that fetching continues while the FIFO is empty, and how many words were fetched but never written. These are checked for the seven-of-eight handshaked case, the full-burst pulsed case, the retry case and randomised mixes of these.

// File: rtl/dma_flow_pkg.sv
package dma_flow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_BURST,
        ST_SRC_ACK,
        ST_WAIT_RETRY,
        ST_FINISH_HS,
        ST_FINISH_PULSE,
        ST_DRAIN
    } src_state_e;

endpackage

// File: rtl/dma_dst_track.sv
module dma_dst_track #(
    parameter int DST_BURST  = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            dst_req,
    input  logic                            dst_single,
    input  logic                            dst_last,
    input  logic                            wr_beat,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
    input  logic                            clr_i,
    output logic                            dst_ack,
    output logic                            last_seen,
    output logic                            dst_done,
    output logic                            need_met
);

    localparam int              CW    = $clog2(DST_BURST + 1);
    localparam logic [CW-1:0]   BLEN  = CW'(DST_BURST);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ack;
        logic          seen;
        logic          done;
    } dst_regs_t;

    dst_regs_t     q, d;
    logic [CW-1:0] len;

    always_comb begin
        d   = q;
        len = dst_single ? CW'(1) : BLEN;
        if (clr_i) begin
            d = '0;
        end else begin
            if (dst_req && dst_single && dst_last) begin
                d.seen = 1'b1;
            end
            if (q.ack) begin
                if (!dst_req) begin
                    d.ack = 1'b0;
                end
            end else if (dst_req && wr_beat) begin
                if (q.cnt + CW'(1) == len) begin
                    d.cnt = '0;
                    d.ack = 1'b1;
                    if (dst_single && dst_last) begin
                        d.done = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dst_ack   = q.ack;
    assign last_seen = q.seen;
    assign dst_done  = q.done;
    assign need_met  = q.seen && (q.done || fifo_count != '0);

    AST_DST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_ack && dst_req && !clr_i) |=> dst_ack); // R3

endmodule

// File: rtl/dma_src_seq.sv
module dma_src_seq
    import dma_flow_pkg::*;
#(
    parameter int SRC_BURST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_req,
    input  logic src_single,
    input  logic rd_beat,
    input  logic rd_resp_retry,
    input  logic stop_i,
    input  logic clr_i,
    output logic src_ack,
    output logic src_finish,
    output logic src_done
);

    localparam int            BW       = $clog2(SRC_BURST + 1);
    localparam logic [BW-1:0] LAST_IDX = BW'(SRC_BURST - 1);

    typedef struct packed {
        src_state_e    st;
        logic [BW-1:0] cnt;
        logic          rp;
    } src_regs_t;

    src_regs_t     q, d;
    logic          ok;
    logic [BW-1:0] last_idx;
    logic          fetching;

    always_comb begin
        d        = q;
        ok       = rd_beat && !rd_resp_retry;
        last_idx = src_single ? '0 : LAST_IDX;
        case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                d.rp  = 1'b0;
                if (stop_i) begin
                    d.st = src_req ? ST_FINISH_HS : ST_FINISH_PULSE;
                end else if (src_req) begin
                    d.st = ST_SRC_BURST;
                end
            end
            ST_SRC_BURST: begin
                if (rd_beat) begin
                    d.rp = rd_resp_retry;
                end
                if (ok) begin
                    d.cnt = q.cnt + BW'(1);
                end
                if (ok && q.cnt == last_idx) begin
                    d.st = ST_SRC_ACK;
                end else if (stop_i) begin
                    d.st = d.rp ? ST_WAIT_RETRY : ST_FINISH_HS;
                end
            end
            ST_WAIT_RETRY: begin
                if (ok) begin
                    d.rp = 1'b0;
                    d.st = ST_FINISH_HS;
                end
            end
            ST_SRC_ACK: begin
                if (!src_req) begin
                    d.st = ST_IDLE;
                end
            end
            ST_FINISH_HS: begin
                if (!src_req) begin
                    d.st = ST_DRAIN;
                end
            end
            ST_FINISH_PULSE: d.st = ST_DRAIN;
            ST_DRAIN: begin
                if (clr_i) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, rp: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign fetching   = (q.st == ST_SRC_BURST) || (q.st == ST_WAIT_RETRY);
    assign src_ack    = (q.st == ST_SRC_ACK) || (q.st == ST_FINISH_HS);
    assign src_finish = (q.st == ST_FINISH_HS) || (q.st == ST_FINISH_PULSE);
    assign src_done   = (q.st == ST_DRAIN);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_finish && !src_ack) |=> !src_finish); // R5
    AST_HS_FINISH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_finish && src_ack && src_req) |=> (src_finish && src_ack)); // R4
    AST_NO_FINISH_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && rd_beat && rd_resp_retry) |=> !src_finish); // R6
    AST_FINISH_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_finish) |-> $past(stop_i)); // R7

endmodule

// File: rtl/dma_flow_ctrl.sv
module dma_flow_ctrl #(
    parameter int SRC_BURST  = 8,
    parameter int DST_BURST  = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            src_req,
    input  logic                            src_single,
    output logic                            src_ack,
    output logic                            src_finish,
    input  logic                            dst_req,
    input  logic                            dst_single,
    input  logic                            dst_last,
    output logic                            dst_ack,
    input  logic                            rd_beat,
    input  logic                            rd_resp_retry,
    input  logic                            wr_beat,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
    output logic                            fifo_clear,
    output logic                            block_done
);

    logic done_d, done_q;
    logic need_met, last_seen, dst_done, src_done, stop;

    assign stop = need_met && !done_q;

    dma_src_seq #(
        .SRC_BURST (SRC_BURST)
    ) u_src (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_req       (src_req),
        .src_single    (src_single),
        .rd_beat       (rd_beat),
        .rd_resp_retry (rd_resp_retry),
        .stop_i        (stop),
        .clr_i         (done_q),
        .src_ack       (src_ack),
        .src_finish    (src_finish),
        .src_done      (src_done)
    );

    dma_dst_track #(
        .DST_BURST  (DST_BURST),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .dst_req    (dst_req),
        .dst_single (dst_single),
        .dst_last   (dst_last),
        .wr_beat    (wr_beat),
        .fifo_count (fifo_count),
        .clr_i      (done_q),
        .dst_ack    (dst_ack),
        .last_seen  (last_seen),
        .dst_done   (dst_done),
        .need_met   (need_met)
    );

    always_comb begin
        done_d = src_done && dst_done && !done_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign block_done = done_q;
    assign fifo_clear = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done); // R8
    AST_FINISH_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        src_finish |-> last_seen); // R4

endmodule

// File: tb/dma_flow_ctrl_tb.sv
`timescale 1ns/1ps
module dma_flow_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_req = 0, src_single = 0, dst_req = 0, dst_single = 0, dst_last = 0;
    logic       rd_beat = 0, rd_resp_retry = 0, wr_beat = 0;
    logic       src_ack, src_finish, dst_ack, fifo_clear, block_done;
    logic [4:0] fifo_count;
    int         fifo_m = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    assign fifo_count = 5'(fifo_m);

    always #2 clk = ~clk;

    dma_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_single(src_single),
        .src_ack(src_ack), .src_finish(src_finish), .dst_req(dst_req),
        .dst_single(dst_single), .dst_last(dst_last), .dst_ack(dst_ack),
        .rd_beat(rd_beat), .rd_resp_retry(rd_resp_retry), .wr_beat(wr_beat),
        .fifo_count(fifo_count), .fifo_clear(fifo_clear), .block_done(block_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int leftover(input int fetched, input int written);
        return fetched - written;
    endfunction

    task automatic src_beats(input int n, input bit retry);
        rd_beat = 1'b1;
        rd_resp_retry = retry;
        for (int i = 0; i < n; i++) begin
            tick();
            if (!retry) fifo_m++;
        end
        rd_beat = 1'b0;
        rd_resp_retry = 1'b0;
    endtask

    task automatic dst_burst();
        dst_req = 1'b1; dst_single = 1'b0; wr_beat = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            fifo_m--;
        end
        wr_beat = 1'b0;
        chk("R3 dst burst ack", dst_ack, 1);
        dst_req = 1'b0;
        tick();
        chk("R3 dst ack drop", dst_ack, 0);
    endtask

    task automatic req_last();
        dst_req = 1'b1; dst_single = 1'b1; dst_last = 1'b1;
    endtask

    task automatic complete(input int exp_left);
        wr_beat = 1'b1;
        tick();
        fifo_m--;
        wr_beat = 1'b0;
        chk("R3 dst single ack", dst_ack, 1);
        dst_req = 1'b0; dst_single = 1'b0; dst_last = 1'b0;
        tick();
        chk("R8 block_done", block_done, 1);
        chk("R8 fifo_clear", fifo_clear, 1);
        chk("R8 words dropped", fifo_m, exp_left);
        fifo_m = 0;
        tick();
        chk("R8 done pulse width", block_done, 0);
    endtask

    // handshaked finish: source request still open at the stop point
    task automatic run_active(input int p, input bit retry);
        int written;
        src_req = 1'b1; src_single = 1'b0;
        tick();
        src_beats(p, 1'b0);
        written = 0;
        if (p >= 5) begin
            dst_burst();
            written = 4;
        end
        if (retry) src_beats(1, 1'b1);
        req_last();
        tick();
        chk("R4 no finish yet", src_finish, 0);
        tick();
        if (retry) begin
            chk("R6 finish withheld", src_finish, 0);
            src_beats(1, 1'b0);
        end
        chk("R4 finish", src_finish, 1);
        chk("R4 ack with finish", src_ack, 1);
        tick();
        chk("R4 finish held", src_finish, 1);
        src_req = 1'b0;
        tick();
        chk("R4 finish drop", src_finish, 0);
        chk("R4 ack drop", src_ack, 0);
        complete(leftover(p + (retry ? 1 : 0), written + 1));
    endtask

    // pulsed finish: source burst already done, no open request
    task automatic run_idle(input bit single);
        int written;
        src_req = 1'b1; src_single = single;
        tick();
        if (single) begin
            src_beats(1, 1'b0);
        end else begin
            src_beats(7, 1'b0);
            chk("R2 no ack before 8th beat", src_ack, 0);
            src_beats(1, 1'b0);
        end
        chk("R2 src ack", src_ack, 1);
        tick();
        chk("R2 src ack held", src_ack, 1);
        src_req = 1'b0; src_single = 1'b0;
        tick();
        chk("R2 src ack drop", src_ack, 0);
        written = 0;
        if (!single) begin
            dst_burst();
            written = 4;
        end
        req_last();
        tick();
        tick();
        chk("R5 finish pulse", src_finish, 1);
        chk("R5 ack low", src_ack, 0);
        tick();
        chk("R5 pulse one cycle", src_finish, 0);
        complete(leftover(single ? 1 : 8, written + 1));
    endtask

    // FIFO empty when the last request arrives
    task automatic run_empty();
        src_req = 1'b1; src_single = 1'b0;
        tick();
        req_last();
        tick();
        tick();
        chk("R7 no finish while empty", src_finish, 0);
        tick();
        chk("R7 still waiting", src_finish, 0);
        src_beats(1, 1'b0);
        chk("R7 finish after count", src_finish, 0);
        tick();
        chk("R7 finish", src_finish, 1);
        src_req = 1'b0;
        tick();
        complete(0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R1 reset src_ack", src_ack, 0);
        chk("R1 reset src_finish", src_finish, 0);
        chk("R1 reset block_done", block_done, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 after reset dst_ack", dst_ack, 0);
        chk("R1 after reset fifo_clear", fifo_clear, 0);
        run_active(7, 1'b0);
        run_idle(1'b0);
        run_active(6, 1'b1);
        run_idle(1'b1);
        run_empty();
        run_active(2, 1'b0);
        for (int i = 0; i < 24; i++) begin
            int mode;
            mode = int'($urandom % 3);
            if (mode == 0) run_active(1 + int'($urandom % 7), bit'($urandom % 2));
            else if (mode == 1) run_idle(bit'($urandom % 2));
            else run_empty();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule